// File: doc/BRIEF.md
# Multi-Bank Digital Test Pattern Injector

This block sits on the sample path of a multi-channel converter and, for each bank of four channels, either passes the live conversion word through or substitutes a synthetic word. The synthetic word comes from one of three generators. The first is a constant. The second is a ramp whose step can be set. The third alternates between two constants. Downstream capture logic can then check the data path against a known sequence, with no analog stimulus.

Each bank has its own configuration: an enable, a 2-bit mode code, a 4-bit ramp step and two pattern words. Each pattern word is assembled from two split fields. A parameter sets how many identical banks are built. Every bank has its own sample strobe. The registered output word and its valid flag appear one clock after the strobe.

Top module: `tpg_bank_array`

## Requirements
- R1: After synchronous reset, every bank drives `dout_vld` low and an all-zero `dout` word.
- R2: With the bank enable at 0, the word presented one cycle after a strobe equals the `conv_data` slice sampled with that strobe, whatever the mode, step and pattern fields hold.
- R3: With the enable at 1 and mode code 0 or 1, every strobe yields pattern 0, which is {`pat0_hi`, `pat0_lo`} with the low field in the least significant bits.
- R4: With the enable at 1 and mode code 2, the first strobe after entering the ramp yields 0, and each later strobe yields the previous ramp word plus (step + 1), for a step value from 0 to 15.
- R5: The ramp wraps modulo 2^W, where W is the pattern word width (24 by default).
- R6: Leaving the ramp, either by clearing the enable or by choosing another mode, for at least one clock, and then returning, makes the ramp restart at 0.
- R7: With the enable at 1 and mode code 3, strobes yield pattern 0, pattern 1, pattern 0 and so on, always starting with pattern 0 when the mode is entered. Pattern 1 is {`pat1_hi`, `pat1_lo`} with the low field in the least significant bits.
- R8: `dout_vld` of a bank is high exactly in the cycle after that bank's strobe. When there is no strobe, `dout` holds its value and no generator advances.
- R9: Banks are independent. A strobe or configuration on one bank does not change another bank's output or sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | NUM_BANKS | Per-bank sample strobe |
| conv_data | input | NUM_BANKS*W | Live conversion words, bank b at [b*W +: W] |
| tp_en | input | NUM_BANKS | Per-bank pattern enable |
| tp_mode | input | NUM_BANKS*2 | Mode codes: 0/1 fixed, 2 ramp, 3 alternate |
| ramp_step | input | NUM_BANKS*STEP_W | Ramp step minus one |
| pat0_lo | input | NUM_BANKS*P0_LO_W | Low field of pattern 0 |
| pat0_hi | input | NUM_BANKS*P0_HI_W | High field of pattern 0 |
| pat1_lo | input | NUM_BANKS*P1_LO_W | Low field of pattern 1 |
| pat1_hi | input | NUM_BANKS*(W-P1_LO_W) | High field of pattern 1 |
| dout | output | NUM_BANKS*W | Registered output words |
| dout_vld | output | NUM_BANKS | Output valid, one cycle after the strobe |

## Verification
The bench runs on a narrow 12-bit build, so the ramp reaches its wrap point within a few hundred strobes. A design that saturates the ramp, or keeps bits beyond the word, reports a wrong word after the wrap. Every step value is swept, so an off-by-one in the step (adding N instead of N+1) shows on the second sample. The bench leaves and re-enters the ramp and alternate modes in several ways. This catches a ramp that resumes where it stopped and an alternation that starts on pattern 1. Strobing one bank while the other sits idle exposes cross-bank leaks and outputs that change without a strobe.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    TPM_CONST_A = 2'd0,
    TPM_CONST_B = 2'd1,
    TPM_RAMP    = 2'd2,
    TPM_TOGGLE  = 2'd3
  } tpm_e;
endpackage

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
  parameter int W      = 24,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              live,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      value
);
  localparam int PAD = W - STEP_W;

  logic [W-1:0] acc;
  logic         armed;
  logic [W-1:0] incr;

  assign incr  = {{PAD{1'b0}}, step} + W'(1);
  assign value = armed ? acc : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      armed <= 1'b0;
    end else if (!live) begin
      armed <= 1'b0;
    end else if (adv) begin
      acc   <= value + incr;
      armed <= 1'b1;
    end
  end

  // R4: the first advance after entry leaves acc at step+1
  p_ramp_first_r4: assert property (@(posedge clk) disable iff (rst)
    (live && adv && !armed) |=> (acc == {{PAD{1'b0}}, $past(step)} + W'(1)));
  // R6: leaving the ramp disarms it
  p_ramp_restart_r6: assert property (@(posedge clk) disable iff (rst)
    !live |=> !armed);
  // R8: no advance, no change
  p_ramp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (live && !adv) |=> $stable(acc));
endmodule

// File: rtl/tpg_alt.sv
module tpg_alt (
  input  logic clk,
  input  logic rst,
  input  logic live,
  input  logic adv,
  output logic sel
);
  logic armed;
  logic tog;

  assign sel = armed ? tog : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      tog   <= 1'b0;
    end else if (!live) begin
      armed <= 1'b0;
    end else if (adv) begin
      tog   <= ~sel;
      armed <= 1'b1;
    end
  end

  // R7: each advance flips the selected word
  p_alt_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (live && adv) |=> (sel != $past(sel)));
  // R7: entry always starts on pattern 0
  p_alt_entry_r7: assert property (@(posedge clk) disable iff (rst)
    !live |=> !sel);
endmodule

// File: rtl/tpg_bank.sv
module tpg_bank
  import tpg_pkg::*;
#(
  parameter int P0_LO_W = 16,
  parameter int P0_HI_W = 8,
  parameter int P1_LO_W = 8,
  parameter int STEP_W  = 4,
  localparam int W       = P0_LO_W + P0_HI_W,
  localparam int P1_HI_W = W - P1_LO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic [W-1:0]       adc,
  input  logic               en,
  input  logic [1:0]         mode,
  input  logic [STEP_W-1:0]  step,
  input  logic [P0_LO_W-1:0] p0_lo,
  input  logic [P0_HI_W-1:0] p0_hi,
  input  logic [P1_LO_W-1:0] p1_lo,
  input  logic [P1_HI_W-1:0] p1_hi,
  output logic [W-1:0]       dout,
  output logic               vld
);
  tpm_e         md;
  logic [W-1:0] pat0, pat1, ramp_val, nxt;
  logic         ramp_live, alt_live, alt_sel;

  assign md        = tpm_e'(mode);
  assign pat0      = {p0_hi, p0_lo};
  assign pat1      = {p1_hi, p1_lo};
  assign ramp_live = en && (md == TPM_RAMP);
  assign alt_live  = en && (md == TPM_TOGGLE);

  tpg_ramp #(.W(W), .STEP_W(STEP_W)) u_ramp (
    .clk(clk), .rst(rst), .live(ramp_live), .adv(stb),
    .step(step), .value(ramp_val)
  );

  tpg_alt u_alt (
    .clk(clk), .rst(rst), .live(alt_live), .adv(stb), .sel(alt_sel)
  );

  always_comb begin
    if (!en) begin
      nxt = adc;
    end else begin
      case (md)
        TPM_RAMP:   nxt = ramp_val;
        TPM_TOGGLE: nxt = alt_sel ? pat1 : pat0;
        default:    nxt = pat0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= stb;
      if (stb) dout <= nxt;
    end
  end

  // R8: valid follows the strobe by one cycle
  p_vld_r8: assert property (@(posedge clk) disable iff (rst)
    stb |=> vld);
  p_novld_r8: assert property (@(posedge clk) disable iff (rst)
    !stb |=> (!vld && $stable(dout)));
  // R2: bypass passes the sampled conversion word
  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (stb && !en) |=> (dout == $past(adc)));
  // R3: fixed codes give pattern 0
  p_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (stb && en && !mode[1]) |=> (dout == {$past(p0_hi), $past(p0_lo)}));
endmodule

// File: rtl/tpg_bank_array.sv
module tpg_bank_array #(
  parameter int NUM_BANKS = 2,
  parameter int P0_LO_W   = 16,
  parameter int P0_HI_W   = 8,
  parameter int P1_LO_W   = 8,
  parameter int STEP_W    = 4,
  localparam int W        = P0_LO_W + P0_HI_W,
  localparam int P1_HI_W  = W - P1_LO_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_BANKS-1:0]           smp_stb,
  input  logic [NUM_BANKS*W-1:0]         conv_data,
  input  logic [NUM_BANKS-1:0]           tp_en,
  input  logic [NUM_BANKS*2-1:0]         tp_mode,
  input  logic [NUM_BANKS*STEP_W-1:0]    ramp_step,
  input  logic [NUM_BANKS*P0_LO_W-1:0]   pat0_lo,
  input  logic [NUM_BANKS*P0_HI_W-1:0]   pat0_hi,
  input  logic [NUM_BANKS*P1_LO_W-1:0]   pat1_lo,
  input  logic [NUM_BANKS*P1_HI_W-1:0]   pat1_hi,
  output logic [NUM_BANKS*W-1:0]         dout,
  output logic [NUM_BANKS-1:0]           dout_vld
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    tpg_bank #(
      .P0_LO_W(P0_LO_W), .P0_HI_W(P0_HI_W),
      .P1_LO_W(P1_LO_W), .STEP_W(STEP_W)
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .stb  (smp_stb[b]),
      .adc  (conv_data[b*W +: W]),
      .en   (tp_en[b]),
      .mode (tp_mode[b*2 +: 2]),
      .step (ramp_step[b*STEP_W +: STEP_W]),
      .p0_lo(pat0_lo[b*P0_LO_W +: P0_LO_W]),
      .p0_hi(pat0_hi[b*P0_HI_W +: P0_HI_W]),
      .p1_lo(pat1_lo[b*P1_LO_W +: P1_LO_W]),
      .p1_hi(pat1_hi[b*P1_HI_W +: P1_HI_W]),
      .dout (dout[b*W +: W]),
      .vld  (dout_vld[b])
    );
  end

  // R1: nothing valid right after reset
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (dout_vld == '0 && dout == '0));
endmodule

// File: tb/test_tpg_bank_array.sv
module test_tpg_bank_array;
  localparam int NB = 2, L0 = 8, H0 = 4, L1 = 4, SW = 4;
  localparam int W = L0 + H0, H1 = W - L1;

  logic clk = 0, rst = 1;
  logic [NB-1:0]    stb = '0, en = '0;
  logic [NB*W-1:0]  adc = '0;
  logic [NB*2-1:0]  mode = '0;
  logic [NB*SW-1:0] step = '0;
  logic [NB*L0-1:0] p0l = '0;
  logic [NB*H0-1:0] p0h = '0;
  logic [NB*L1-1:0] p1l = '0;
  logic [NB*H1-1:0] p1h = '0;
  logic [NB*W-1:0]  dout;
  logic [NB-1:0]    vld;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [W-1:0] m_acc[NB], m_last[NB];
  bit m_rarm[NB], m_aarm[NB], m_tog[NB];

  always #10 clk = ~clk;

  tpg_bank_array #(.NUM_BANKS(NB), .P0_LO_W(L0), .P0_HI_W(H0),
                   .P1_LO_W(L1), .STEP_W(SW)) i_tpg_bank_array (
    .clk(clk), .rst(rst), .smp_stb(stb), .conv_data(adc), .tp_en(en),
    .tp_mode(mode), .ramp_step(step), .pat0_lo(p0l), .pat0_hi(p0h),
    .pat1_lo(p1l), .pat1_hi(p1h), .dout(dout), .dout_vld(vld));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(int b, bit e, logic [1:0] m, logic [SW-1:0] s);
    en[b] = e; mode[b*2 +: 2] = m; step[b*SW +: SW] = s;
    @(negedge clk);
    if (!(e && m == 2)) m_rarm[b] = 0;
    if (!(e && m == 3)) m_aarm[b] = 0;
    chk("R8 idle vld", 32'(vld[b]), 0);
  endtask

  task automatic pats(int b, logic [L0-1:0] a, logic [H0-1:0] c,
                      logic [L1-1:0] d, logic [H1-1:0] f);
    p0l[b*L0 +: L0] = a; p0h[b*H0 +: H0] = c;
    p1l[b*L1 +: L1] = d; p1h[b*H1 +: H1] = f;
  endtask

  task automatic pulse(logic [NB-1:0] mask, string req);
    for (int b = 0; b < NB; b++) begin
      if (mask[b]) begin
        logic [W-1:0] e;
        logic [W-1:0] p0, p1;
        p0 = {p0h[b*H0 +: H0], p0l[b*L0 +: L0]};
        p1 = {p1h[b*H1 +: H1], p1l[b*L1 +: L1]};
        if (!en[b]) e = adc[b*W +: W];
        else begin
          case (mode[b*2 +: 2])
            2: begin
              e = m_rarm[b] ? m_acc[b] : '0;
              m_acc[b] = W'(32'(e) + 32'(step[b*SW +: SW]) + 1);
              m_rarm[b] = 1;
            end
            3: begin
              bit s = m_aarm[b] ? m_tog[b] : 1'b0;
              e = s ? p1 : p0;
              m_tog[b] = ~s; m_aarm[b] = 1;
            end
            default: e = p0;
          endcase
        end
        m_last[b] = e;
      end
    end
    stb = mask;
    @(negedge clk);
    stb = '0;
    for (int b = 0; b < NB; b++) begin
      chk({req, mask[b] ? " vld" : " R9 no-vld"}, 32'(vld[b]), 32'(mask[b]));
      chk({req, mask[b] ? " data" : " R9 hold"}, 32'(dout[b*W +: W]), 32'(m_last[b]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_acc[b] = '0; m_last[b] = '0; m_rarm[b] = 0; m_aarm[b] = 0; m_tog[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 vld", 32'(vld), 0);
    chk("R1 data", 32'(dout), 0);

    // R2 bypass, mode and patterns set to distractors
    pats(0, 8'hA5, 4'h3, 4'h9, 8'h7E);
    pats(1, 8'h11, 4'hC, 4'h2, 8'h44);
    for (int b = 0; b < NB; b++) cfg(b, 0, 2'(b + 2), 4'hF);
    for (int k = 0; k < 12; k++) begin
      adc = {12'(k * 397 + 5), 12'(4095 - k * 211)};
      pulse(2'b11, "R2 bypass");
    end

    // R3 fixed pattern, codes 0 and 1, several words
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < NB; b++) cfg(b, 1, 2'(m), 4'(b));
      for (int k = 0; k < 4; k++) begin
        pats(0, 8'(k * 37), 4'(k + 1), 4'(k), 8'(k * 5));
        pats(1, 8'(255 - k), 4'(15 - k), 4'(k), 8'(k));
        pulse(2'b11, "R3 fixed");
      end
    end

    // R4 ramp step sweep, with exit between steps (R6)
    for (int s = 0; s < 16; s++) begin
      cfg(0, 1, 2'd2, 4'(s));
      cfg(1, 1, 2'd2, 4'(15 - s));
      for (int k = 0; k < 4; k++) pulse(2'b11, "R4 ramp");
      cfg(0, 1, 2'd0, 4'(s));
      cfg(1, 0, 2'd2, 4'(s));
    end

    // R6 restart via enable and via mode change
    cfg(0, 1, 2'd2, 4'd6);
    for (int k = 0; k < 3; k++) pulse(2'b01, "R6 pre");
    cfg(0, 0, 2'd2, 4'd6);
    cfg(0, 1, 2'd2, 4'd6);
    pulse(2'b01, "R6 restart-en");
    pulse(2'b01, "R6 second");
    cfg(0, 1, 2'd3, 4'd6);
    cfg(0, 1, 2'd2, 4'd6);
    pulse(2'b01, "R6 restart-mode");

    // R5 wrap: 300 steps of 16 cross 4096
    cfg(0, 1, 2'd0, 4'd15);
    cfg(0, 1, 2'd2, 4'd15);
    for (int k = 0; k < 300; k++) pulse(2'b01, "R5 wrap");

    // R7 alternate, re-entry restarts on pattern 0; R9 bank 1 idle
    pats(0, 8'h5A, 4'h6, 4'hB, 8'hD2);
    cfg(1, 1, 2'd3, 4'd0);
    cfg(0, 1, 2'd3, 4'd0);
    for (int k = 0; k < 5; k++) pulse(2'b01, "R7 alt");
    cfg(0, 1, 2'd1, 4'd0);
    cfg(0, 1, 2'd3, 4'd0);
    for (int k = 0; k < 3; k++) pulse(2'b01, "R7 re-entry");
    for (int k = 0; k < 3; k++) pulse(2'b10, "R9 bank1 alt");
    for (int k = 0; k < 2; k++) pulse(2'b11, "R7 both");

    // R8 hold with no strobe
    adc = '1;
    repeat (3) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin
        chk("R8 no-vld", 32'(vld[b]), 0);
        chk("R8 hold", 32'(dout[b*W +: W]), 32'(m_last[b]));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule